// File: doc/BRIEF.md
# Stop-Clock Throttling Sequencer

This block lowers processor power by asking the processor to halt its clock. The request is an active-low output. It is pulsed on a repeating schedule set by two programmable interval counts, and an external thermal trip input can also force it on. The interval counts are measured in ticks of a prescaled clock, and a zero in either count turns the periodic schedule off.

When the processor answers the request with a stop-grant bus cycle, the block acknowledges it. If the disconnect-enable configuration bit is set, the block then takes the memory side down in order. It asks the internal queues to drain and waits for their completion handshake. Only after that does it ask the DRAM controller to enter self-refresh. When the halt request ends, it first withdraws the self-refresh request and only then reopens acceptance of new requests. When the disconnect-enable bit is clear, the stop-grant cycle is acknowledged and nothing else happens. The same path serves both the periodic throttle and the idle halt state.

Top module: `clk_throttle_seq`

## Requirements
- R1: In the first cycle after reset, `halt_req_n`=1, `grant_ack`=0, `flush_req`=0, `sref_req`=0 and `req_accept`=1.
- R2: When both interval counts are nonzero and `thermal_trip` is low, `halt_req_n` repeats a pattern: low for `cfg_on_ticks`×PRESCALE_DIV cycles, then high for `cfg_off_ticks`×PRESCALE_DIV cycles.
- R3: When either interval count is zero and `thermal_trip` is low, `halt_req_n` stays high.
- R4: A rise of `thermal_trip` drives `halt_req_n` low exactly SYNC_STAGES+1 clock edges later. It stays low while the trip is held, and goes high again the same number of edges after the trip falls.
- R5: A `stop_grant_cyc` pulse that arrives while `req_accept` is high gives a `grant_ack` pulse exactly one cycle wide on the next edge.
- R6: With `cfg_disc_en`=1, that same edge raises `flush_req` and drops `req_accept`.
- R7: `sref_req` rises only on the edge that samples `flush_done`, and only while the halt request is still active. `flush_req` falls on that same edge.
- R8: When `halt_req_n` returns high while `sref_req` is high, `sref_req` falls one edge later and `req_accept` rises one edge after that.
- R9: With `cfg_disc_en`=0, a stop-grant cycle produces only the `grant_ack` pulse. `flush_req` and `sref_req` stay low and `req_accept` stays high.
- R10: If the halt request ends before `flush_done` arrives, `flush_done` drops `flush_req` without raising `sref_req`, and `req_accept` rises one edge later.
- R11: `req_accept` is never high together with `flush_req` or `sref_req`, and `flush_req` and `sref_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on_ticks | input | CNT_W | Prescaled ticks the halt request stays asserted per period |
| cfg_off_ticks | input | CNT_W | Prescaled ticks the halt request stays released per period |
| cfg_disc_en | input | 1 | Enables the queue-flush and self-refresh sequence after a stop-grant |
| thermal_trip | input | 1 | Asynchronous thermal trigger that forces the halt request |
| stop_grant_cyc | input | 1 | One-cycle pulse: stop-grant bus cycle received |
| flush_done | input | 1 | One-cycle pulse: internal queues are drained |
| halt_req_n | output | 1 | Active-low stop-clock request to the processor |
| grant_ack | output | 1 | One-cycle acknowledge of a stop-grant cycle |
| flush_req | output | 1 | Request to drain the internal queues |
| sref_req | output | 1 | Request for DRAM self-refresh; deasserting it asks for exit |
| req_accept | output | 1 | High when new memory requests may be accepted |

## Verification
The bench builds the block with PRESCALE_DIV=2, SYNC_STAGES=2 and 8-bit counts. The short prescaler makes whole on and off periods take only tens of cycles, so exact interval lengths and the zero-count disable are checked directly. Two synchronizer stages make the thermal latency a fixed three edges, which the bench samples on both sides. The three disconnect orderings are compared event by event against an expected queue: a full flush and self-refresh, disconnect disabled, and the halt ending while the flush is still pending.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_SREF  = 2'd2,
    ST_EXIT  = 2'd3
  } disc_state_t;
endpackage

// File: rtl/throttle_prescaler.sv
module throttle_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (pc == LAST) pc <= '0;
    else                 pc <= pc + 1'b1;
  end

  assign tick = (pc == LAST);
endmodule

// File: rtl/throttle_interval.sv
module throttle_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] on_ticks,
  input  logic [CNT_W-1:0] off_ticks,
  output logic             phase_on
);
  logic [CNT_W-1:0] cnt;
  logic             per_en;
  logic [CNT_W:0]   next_cnt;
  logic [CNT_W:0]   limit;

  assign per_en   = (|on_ticks) && (|off_ticks);
  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign limit    = phase_on ? {1'b0, on_ticks} : {1'b0, off_ticks};

  always_ff @(posedge clk) begin
    if (rst || !per_en) begin
      phase_on <= 1'b0;
      cnt      <= '0;
    end else if (tick) begin
      if (next_cnt >= limit) begin
        phase_on <= ~phase_on;
        cnt      <= '0;
      end else begin
        cnt <= next_cnt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/throttle_sync.sv
module throttle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/throttle_disconnect.sv
module throttle_disconnect
  import throttle_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stop_active,
  input  logic grant_cyc,
  input  logic disc_en,
  input  logic flush_done,
  output logic grant_ack,
  output logic flush_req,
  output logic sref_req,
  output logic req_accept
);
  disc_state_t st, nxt;
  logic        ack_nxt;

  always_comb begin
    nxt     = st;
    ack_nxt = 1'b0;
    case (st)
      ST_IDLE: begin
        if (grant_cyc) begin
          ack_nxt = 1'b1;
          if (disc_en) nxt = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (flush_done) nxt = stop_active ? ST_SREF : ST_EXIT;
      end
      ST_SREF: begin
        if (!stop_active) nxt = ST_EXIT;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      grant_ack  <= 1'b0;
      flush_req  <= 1'b0;
      sref_req   <= 1'b0;
      req_accept <= 1'b1;
    end else begin
      st         <= nxt;
      grant_ack  <= ack_nxt;
      flush_req  <= (nxt == ST_FLUSH);
      sref_req   <= (nxt == ST_SREF);
      req_accept <= (nxt == ST_IDLE);
    end
  end
endmodule

// File: rtl/clk_throttle_seq.sv
module clk_throttle_seq #(
  parameter int CNT_W        = 8,
  parameter int PRESCALE_DIV = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_on_ticks,
  input  logic [CNT_W-1:0] cfg_off_ticks,
  input  logic             cfg_disc_en,
  input  logic             thermal_trip,
  input  logic             stop_grant_cyc,
  input  logic             flush_done,
  output logic             halt_req_n,
  output logic             grant_ack,
  output logic             flush_req,
  output logic             sref_req,
  output logic             req_accept
);
  logic tick;
  logic phase_on;
  logic trip_s;

  throttle_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  throttle_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .on_ticks  (cfg_on_ticks),
    .off_ticks (cfg_off_ticks),
    .phase_on  (phase_on)
  );

  throttle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (thermal_trip),
    .q   (trip_s)
  );

  always_ff @(posedge clk) begin
    if (rst) halt_req_n <= 1'b1;
    else     halt_req_n <= ~(phase_on | trip_s);
  end

  throttle_disconnect u_disc (
    .clk         (clk),
    .rst         (rst),
    .stop_active (~halt_req_n),
    .grant_cyc   (stop_grant_cyc),
    .disc_en     (cfg_disc_en),
    .flush_done  (flush_done),
    .grant_ack   (grant_ack),
    .flush_req   (flush_req),
    .sref_req    (sref_req),
    .req_accept  (req_accept)
  );
endmodule

// File: rtl/clk_throttle_seq_chk.sv
module clk_throttle_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_disc_en,
  input logic stop_grant_cyc,
  input logic flush_done,
  input logic halt_req_n,
  input logic grant_ack,
  input logic flush_req,
  input logic sref_req,
  input logic req_accept
);
  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    grant_ack |=> !grant_ack);

  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_req) |-> ($past(stop_grant_cyc) && $past(cfg_disc_en)));

  // R7
  sref_after_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sref_req) |-> ($past(flush_req) && $past(flush_done) && !halt_req_n));

  // R8
  sref_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sref_req) |-> (halt_req_n && !req_accept));

  // R10
  accept_return_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_accept) |-> ($past(!flush_req) && $past(!sref_req)));

  // R11
  accept_excl_chk: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> (!flush_req && !sref_req));

  // R11
  flush_sref_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(flush_req && sref_req));
endmodule

bind clk_throttle_seq clk_throttle_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_disc_en    (cfg_disc_en),
  .stop_grant_cyc (stop_grant_cyc),
  .flush_done     (flush_done),
  .halt_req_n     (halt_req_n),
  .grant_ack      (grant_ack),
  .flush_req      (flush_req),
  .sref_req       (sref_req),
  .req_accept     (req_accept)
);

// File: tb/tb_clk_throttle_seq.sv
`timescale 1ns/1ps
module tb_clk_throttle_seq;
  localparam int CNT_W = 8;
  localparam int DIV   = 2;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cfg_on_ticks = '0;
  logic [CNT_W-1:0] cfg_off_ticks = '0;
  logic             cfg_disc_en = 1'b0;
  logic             thermal_trip = 1'b0;
  logic             stop_grant_cyc = 1'b0;
  logic             flush_done = 1'b0;
  logic             halt_req_n, grant_ack, flush_req, sref_req, req_accept;

  clk_throttle_seq #(.CNT_W(CNT_W), .PRESCALE_DIV(DIV), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .cfg_on_ticks(cfg_on_ticks), .cfg_off_ticks(cfg_off_ticks),
    .cfg_disc_en(cfg_disc_en), .thermal_trip(thermal_trip), .stop_grant_cyc(stop_grant_cyc),
    .flush_done(flush_done), .halt_req_n(halt_req_n), .grant_ack(grant_ack),
    .flush_req(flush_req), .sref_req(sref_req), .req_accept(req_accept)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [4:0] evq[$];
  string      tagq[$];
  logic [4:0] prev = 5'b10001;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected output snapshot {halt_req_n, grant_ack, flush_req, sref_req, req_accept}
  task automatic expect_evt(input logic [4:0] e, input string req);
    evq.push_back(e);
    tagq.push_back(req);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_grant();
    @(negedge clk) stop_grant_cyc = 1'b1;
    @(negedge clk) stop_grant_cyc = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk) flush_done = 1'b1;
    @(negedge clk) flush_done = 1'b0;
  endtask

  // monitor: pops the expected snapshot on each output change
  always @(negedge clk) begin
    logic [4:0] snap;
    snap = {halt_req_n, grant_ack, flush_req, sref_req, req_accept};
    if (!rst && mon_en && snap != prev) begin
      if (evq.size() == 0) check(1'b0, "unexpected change", int'(snap), int'(prev));
      else begin
        logic [4:0] e;
        string t;
        e = evq.pop_front();
        t = tagq.pop_front();
        check(snap == e, t, int'(snap), int'(e));
      end
    end
    prev = snap;
  end

  task automatic measure(input string req, input int exp_lo, input int exp_hi);
    int n;
    int guard;
    guard = 0;
    while (halt_req_n !== 1'b1 && guard < 1000) begin @(negedge clk); guard++; end
    while (halt_req_n !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
    for (int k = 0; k < 2; k++) begin
      n = 0;
      while (halt_req_n === 1'b0 && n < 1000) begin @(negedge clk); n++; end
      check(n == exp_lo, req, n, exp_lo);
      n = 0;
      while (halt_req_n === 1'b1 && n < 1000) begin @(negedge clk); n++; end
      check(n == exp_hi, req, n, exp_hi);
    end
  endtask

  task automatic hold_high(input string req, input int n);
    bit ok;
    ok = 1'b1;
    cyc(4);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (halt_req_n !== 1'b1) ok = 1'b0;
    end
    check(ok, req, int'(halt_req_n), 1);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({halt_req_n, grant_ack, flush_req, sref_req, req_accept} == 5'b10001, "R1",
          int'({halt_req_n, grant_ack, flush_req, sref_req, req_accept}), 5'h11);

    // R2 periodic pattern
    cfg_on_ticks = 8'd3; cfg_off_ticks = 8'd5;
    measure("R2", 3 * DIV, 5 * DIV);
    cfg_on_ticks = 8'd1; cfg_off_ticks = 8'd2;
    measure("R2", 1 * DIV, 2 * DIV);

    // R3 zero count disables
    cfg_on_ticks = 8'd0; cfg_off_ticks = 8'd5;
    hold_high("R3", 60);
    cfg_on_ticks = 8'd4; cfg_off_ticks = 8'd0;
    hold_high("R3", 60);
    cfg_on_ticks = 8'd0;

    // R4 thermal latency
    @(negedge clk) thermal_trip = 1'b1;
    cyc(SYNC);
    check(halt_req_n === 1'b1, "R4", int'(halt_req_n), 1);
    cyc(1);
    check(halt_req_n === 1'b0, "R4", int'(halt_req_n), 0);
    cyc(10);
    check(halt_req_n === 1'b0, "R4", int'(halt_req_n), 0);
    thermal_trip = 1'b0;
    cyc(SYNC);
    check(halt_req_n === 1'b0, "R4", int'(halt_req_n), 0);
    cyc(1);
    check(halt_req_n === 1'b1, "R4", int'(halt_req_n), 1);
    cyc(3);

    // full flush and self-refresh: R5 R6 R7 R8
    mon_en = 1'b1;
    cfg_disc_en = 1'b1;
    expect_evt(5'b00001, "R4");
    thermal_trip = 1'b1;
    cyc(5);
    expect_evt(5'b01100, "R6");
    expect_evt(5'b00100, "R5");
    pulse_grant();
    cyc(10);
    expect_evt(5'b00010, "R7");
    pulse_flush();
    cyc(5);
    expect_evt(5'b10010, "R4");
    expect_evt(5'b10000, "R8");
    expect_evt(5'b10001, "R8");
    thermal_trip = 1'b0;
    cyc(8);
    check(evq.size() == 0, "R8", evq.size(), 0);

    // disconnect disabled: R9
    cfg_disc_en = 1'b0;
    expect_evt(5'b00001, "R4");
    thermal_trip = 1'b1;
    cyc(5);
    expect_evt(5'b01001, "R9");
    expect_evt(5'b00001, "R9");
    pulse_grant();
    cyc(6);
    pulse_flush();
    cyc(3);
    expect_evt(5'b10001, "R9");
    thermal_trip = 1'b0;
    cyc(6);
    check(evq.size() == 0, "R9", evq.size(), 0);

    // halt ends before flush completes: R10
    cfg_disc_en = 1'b1;
    expect_evt(5'b00001, "R4");
    thermal_trip = 1'b1;
    cyc(5);
    expect_evt(5'b01100, "R6");
    expect_evt(5'b00100, "R5");
    pulse_grant();
    cyc(4);
    expect_evt(5'b10100, "R10");
    thermal_trip = 1'b0;
    cyc(6);
    expect_evt(5'b10000, "R10");
    expect_evt(5'b10001, "R10");
    pulse_flush();
    cyc(5);
    check(evq.size() == 0, "R10", evq.size(), 0);
    // R11 final idle outputs
    check({flush_req, sref_req, req_accept} == 3'b001, "R11",
          int'({flush_req, sref_req, req_accept}), 1);

    mon_en = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule